// File: doc/BRIEF.md
# External Bus Strobe and Reset Qualifier

This block generates the two external-bus strobes of a classic 8-bit microcontroller core from the oscillator clock. The first is the address latch strobe, active high. The second is the program fetch read strobe, active low. The block also turns the raw reset pin into a qualified core reset. A machine cycle lasts a fixed number of oscillator clocks, and the block's phase counter walks through it. Each strobe is a decode of that phase together with two per-cycle flags, which the core supplies a cycle ahead: "this cycle fetches code from outside" and "this cycle reads or writes external data memory".

On an external data cycle, the program-read pulses are suppressed and the second address strobe of the cycle is dropped. A register bit can silence the address strobe completely. The raw reset pin is first synchronised. It then has to stay high for more than two whole machine cycles before the core is reset, so shorter glitches are filtered out. While the core reset is active, both strobes are idle and the phase counter is parked at zero.

All pins are plain level signals. No data stream passes through this block, so it has no valid/ready handshake.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While `arst_n` is low, `core_rst` is 1, `phase` is 0, `ale` is 0 and `psen_n` is 1.
- R2: When `core_rst` is 0, `phase` advances by one per clock from 0 to 11 and then wraps to 0, so one machine cycle is 12 clocks.
- R3: With no suppression in force, `ale` is high in phases 0-1 and 6-7. This gives two pulses per machine cycle, each two clocks wide, at one sixth of the clock rate.
- R4: In a cycle whose data flag is set, the `ale` pulse at phases 6-7 is skipped. The pulse at phases 0-1 remains.
- R5: While `ale_off` is 1, `ale` is 0 in every phase. `ale_off` has no effect on `psen_n` or `phase`.
- R6: In a cycle whose fetch flag is set and whose data flag is clear, `psen_n` is low in phases 3-4 and 9-10, which is two pulses per cycle. In every other case it is high.
- R7: In a cycle whose data flag is set, `psen_n` stays high for all 12 phases, even when the fetch flag is also set.
- R8: The per-cycle flags are taken from `ext_fetch` and `ext_data` at the clock edge where `phase` leaves 11, or at any edge while the core reset is active. Changes to these inputs at other times have no effect on the cycle in progress.
- R9: `rst_pin` passes through a 2-stage synchroniser. `core_rst` rises once the synchronised pin has been sampled high on 25 consecutive clocks, which is more than two machine cycles. A high pulse of 24 clocks or fewer never asserts `core_rst`.
- R10: `core_rst` falls at the first clock edge at which the synchronised pin is sampled low, which is the third edge after `rst_pin` goes low.
- R11: While `core_rst` is 1, `ale` is 0, `psen_n` is 1 and `phase` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw external reset pin, active high |
| ext_fetch | input | 1 | Next cycle fetches code from external memory |
| ext_data | input | 1 | Next cycle accesses external data memory |
| ale_off | input | 1 | Register bit that disables the address strobe |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program fetch read strobe, active low |
| phase | output | 4 | Position within the machine cycle, 0 to 11 |
| core_rst | output | 1 | Qualified internal reset, active high |

## Verification
The bench builds the block with its defaults: 12 clocks per cycle, 2 clocks per state, two qualifying machine cycles and a 2-stage synchroniser. With these values the 25-sample qualification window is short enough to probe on both sides of its edge, at 24 and 26 high clocks. Every flag combination can be placed on chosen machine cycles. A flag toggled in the middle of a cycle shows that sampling happens only at the cycle boundary.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  // oscillator clocks per machine cycle (six states of STATE_CLKS each)
  parameter int CYC_CLKS    = 12;
  parameter int STATE_CLKS  = 2;
  // machine cycles the reset pin must exceed before it is accepted
  parameter int QUAL_CYCLES = 2;
  parameter int SYNC_STAGES = 2;

  typedef struct packed {
    logic fetch;
    logic data;
  } cyc_flags_t;
endpackage

// File: rtl/xbus_rst_qual.sv
module xbus_rst_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_LEN    = 25
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin,
  output logic core_rst
);
  localparam int CW = $clog2(QUAL_LEN + 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(QUAL_LEN);
  localparam logic [CW-1:0] CNT_FIRE = CW'(QUAL_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic [CW-1:0]          hi_cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hi_cnt   <= '0;
      core_rst <= 1'b1;
    end else begin
      if (!pin_s)                hi_cnt <= '0;
      else if (hi_cnt != CNT_TOP) hi_cnt <= hi_cnt + 1'b1;
      core_rst <= pin_s && (core_rst || (hi_cnt == CNT_FIRE));
    end
  end
endmodule

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
  parameter int CYC_CLKS = 12,
  localparam int PH_W    = $clog2(CYC_CLKS)
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            hold,
  output logic [PH_W-1:0] phase,
  output logic            last
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_CLKS - 1);

  assign last = (phase == PH_LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   phase <= '0;
    else if (hold) phase <= '0;
    else if (last) phase <= '0;
    else           phase <= phase + 1'b1;
  end
endmodule

// File: rtl/xbus_cycle_flags.sv
module xbus_cycle_flags
  import xbus_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       load,
  input  logic       fetch_in,
  input  logic       data_in,
  output cyc_flags_t flags
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   flags <= '0;
    else if (load) flags <= '{fetch: fetch_in, data: data_in};
  end
endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
  import xbus_pkg::*;
#(
  parameter int CYC_CLKS   = 12,
  parameter int STATE_CLKS = 2,
  localparam int PH_W      = $clog2(CYC_CLKS)
) (
  input  logic [PH_W-1:0] phase,
  input  cyc_flags_t      flags,
  input  logic            run,
  input  logic            ale_off,
  output logic            ale,
  output logic            psen_n
);
  localparam int HALF = CYC_CLKS / 2;
  localparam int QTR  = HALF / 2;
  // two windows per machine cycle: one starting at 0, one at HALF
  localparam logic [PH_W-1:0] A0_LO = PH_W'(0);
  localparam logic [PH_W-1:0] A0_HI = PH_W'(STATE_CLKS);
  localparam logic [PH_W-1:0] A1_LO = PH_W'(HALF);
  localparam logic [PH_W-1:0] A1_HI = PH_W'(HALF + STATE_CLKS);
  localparam logic [PH_W-1:0] P0_LO = PH_W'(QTR);
  localparam logic [PH_W-1:0] P0_HI = PH_W'(QTR + STATE_CLKS);
  localparam logic [PH_W-1:0] P1_LO = PH_W'(HALF + QTR);
  localparam logic [PH_W-1:0] P1_HI = PH_W'(HALF + QTR + STATE_CLKS);

  logic ale_win0, ale_win1, rd_win0, rd_win1;

  always_comb begin
    ale_win0 = (phase >= A0_LO) && (phase < A0_HI);
    ale_win1 = (phase >= A1_LO) && (phase < A1_HI);
    rd_win0  = (phase >= P0_LO) && (phase < P0_HI);
    rd_win1  = (phase >= P1_LO) && (phase < P1_HI);
    ale      = run && !ale_off && (ale_win0 || (ale_win1 && !flags.data));
    psen_n   = !(run && flags.fetch && !flags.data && (rd_win0 || rd_win1));
  end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_pkg::*;
#(
  parameter int CYC_CLKS    = xbus_pkg::CYC_CLKS,
  parameter int STATE_CLKS  = xbus_pkg::STATE_CLKS,
  parameter int QUAL_CYCLES = xbus_pkg::QUAL_CYCLES,
  parameter int SYNC_STAGES = xbus_pkg::SYNC_STAGES,
  localparam int PH_W       = $clog2(CYC_CLKS),
  localparam int QUAL_LEN   = QUAL_CYCLES * CYC_CLKS + 1
) (
  input  logic            clk_osc,
  input  logic            arst_n,
  input  logic            rst_pin,
  input  logic            ext_fetch,
  input  logic            ext_data,
  input  logic            ale_off,
  output logic            ale,
  output logic            psen_n,
  output logic [PH_W-1:0] phase,
  output logic            core_rst
);
  logic       cyc_last;
  cyc_flags_t flags;

  xbus_rst_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_LEN(QUAL_LEN)) u_rstq (
    .clk(clk_osc), .arst_n(arst_n), .pin(rst_pin), .core_rst(core_rst)
  );

  xbus_phase_ctr #(.CYC_CLKS(CYC_CLKS)) u_ph (
    .clk(clk_osc), .arst_n(arst_n), .hold(core_rst), .phase(phase), .last(cyc_last)
  );

  xbus_cycle_flags u_flags (
    .clk(clk_osc), .arst_n(arst_n), .load(core_rst || cyc_last),
    .fetch_in(ext_fetch), .data_in(ext_data), .flags(flags)
  );

  xbus_strobe_dec #(.CYC_CLKS(CYC_CLKS), .STATE_CLKS(STATE_CLKS)) u_dec (
    .phase(phase), .flags(flags), .run(!core_rst), .ale_off(ale_off),
    .ale(ale), .psen_n(psen_n)
  );
endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk #(
  parameter int CYC_CLKS = 12,
  parameter int QUAL_LEN = 25,
  localparam int PH_W    = $clog2(CYC_CLKS),
  localparam int RW      = $clog2(QUAL_LEN + 1)
) (
  input logic            clk_osc,
  input logic            arst_n,
  input logic            rst_pin,
  input logic            ale_off,
  input logic            ale,
  input logic            psen_n,
  input logic [PH_W-1:0] phase,
  input logic            core_rst
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_CLKS - 1);
  localparam logic [PH_W-1:0] RD_A    = PH_W'(CYC_CLKS / 4);
  localparam logic [PH_W-1:0] RD_B    = PH_W'(CYC_CLKS / 2 + CYC_CLKS / 4);
  localparam logic [RW-1:0]   RUN_TOP = RW'(QUAL_LEN);

  logic [RW-1:0] pin_run;
  always_ff @(posedge clk_osc or negedge arst_n) begin
    if (!arst_n)              pin_run <= '0;
    else if (!rst_pin)        pin_run <= '0;
    else if (pin_run != RUN_TOP) pin_run <= pin_run + 1'b1;
  end

  // R2
  phase_wrap_chk: assert property (@(posedge clk_osc) disable iff (!arst_n)
    (!core_rst && phase == PH_LAST) |=> phase == '0);
  // R2
  phase_step_chk: assert property (@(posedge clk_osc) disable iff (!arst_n)
    (!core_rst && phase != PH_LAST) |=> phase == $past(phase) + 1'b1);
  // R11
  rst_idle_chk: assert property (@(posedge clk_osc) disable iff (!arst_n)
    core_rst |-> (!ale && psen_n));
  // R11
  rst_park_chk: assert property (@(posedge clk_osc) disable iff (!arst_n)
    core_rst |=> phase == '0);
  // R5
  ale_off_chk: assert property (@(posedge clk_osc) disable iff (!arst_n)
    ale_off |-> !ale);
  // R6
  psen_start_chk: assert property (@(posedge clk_osc) disable iff (!arst_n)
    $fell(psen_n) |-> (phase == RD_A || phase == RD_B));
  // R9
  rst_qual_chk: assert property (@(posedge clk_osc) disable iff (!arst_n)
    $rose(core_rst) |-> pin_run >= RUN_TOP);
endmodule

bind xbus_strobe_gen xbus_strobe_chk #(.CYC_CLKS(CYC_CLKS), .QUAL_LEN(QUAL_LEN)) u_chk (
  .clk_osc(clk_osc), .arst_n(arst_n), .rst_pin(rst_pin), .ale_off(ale_off),
  .ale(ale), .psen_n(psen_n), .phase(phase), .core_rst(core_rst)
);

// File: tb/test_xbus_strobe_gen.sv
`timescale 1ns/1ps
module test_xbus_strobe_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CYC  = 12;
  localparam int QUAL = 25;
  localparam int SYNC = 2;

  logic clk = 0;
  logic arst_n = 0, rst_pin = 0, ext_fetch = 0, ext_data = 0, ale_off = 0;
  logic ale, psen_n, core_rst;
  logic [3:0] phase;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_strobe_gen i_xbus_strobe_gen (
    .clk_osc(clk), .arst_n(arst_n), .rst_pin(rst_pin), .ext_fetch(ext_fetch),
    .ext_data(ext_data), .ale_off(ale_off), .ale(ale), .psen_n(psen_n),
    .phase(phase), .core_rst(core_rst)
  );

  // behavioural reference, advanced on every rising edge
  int   m_sq[$] = '{0, 0};
  int   m_hi = 0, m_ph = 0;
  bit   m_rst = 1, m_fq = 0, m_dq = 0;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_sq = '{0, 0}; m_hi = 0; m_ph = 0; m_rst = 1; m_fq = 0; m_dq = 0;
    end else begin
      int  s_last;
      int  n_hi, n_ph;
      bit  n_rst;
      s_last = m_sq[SYNC-1];
      n_hi  = (s_last == 0) ? 0 : ((m_hi >= QUAL) ? QUAL : m_hi + 1);
      n_rst = (s_last != 0) && (m_rst || m_hi == QUAL - 1);
      n_ph  = m_rst ? 0 : ((m_ph + 1) % CYC);
      if (m_rst || m_ph == CYC - 1) begin m_fq = ext_fetch; m_dq = ext_data; end
      m_sq.push_front(int'(rst_pin));
      void'(m_sq.pop_back());
      m_hi = n_hi; m_rst = n_rst; m_ph = n_ph;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    #3;
    if (arst_n) begin
      bit e_ale, e_psn;
      e_ale = !m_rst && !ale_off && (m_ph < 2 || (m_ph >= 6 && m_ph < 8 && !m_dq));
      e_psn = !(!m_rst && m_fq && !m_dq && (m_ph == 3 || m_ph == 4 || m_ph == 9 || m_ph == 10));
      check("R2 phase", int'(phase), m_ph);
      check("R3/R4/R5 ale", int'(ale), int'(e_ale));
      check("R6/R7 psen_n", int'(psen_n), int'(e_psn));
      check("R9/R10 core_rst", int'(core_rst), int'(m_rst));
    end
  end

  task automatic wait_last_phase();
    forever begin
      @(negedge clk); #3;
      if (phase == 4'd11) break;
    end
  endtask

  // program flags for the next machine cycle, then observe it
  task automatic run_cycle(bit f, bit d, bit mid_toggle, output int ale_p, output int psn_p);
    bit pa, pp;
    wait_last_phase();
    ext_fetch = f; ext_data = d;
    pa = ale; pp = psen_n; ale_p = 0; psn_p = 0;
    for (int i = 0; i < CYC; i++) begin
      @(negedge clk); #3;
      if (ale && !pa) ale_p++;
      if (!psen_n && pp) psn_p++;
      pa = ale; pp = psen_n;
      if (mid_toggle && i == 2) ext_data = 1;
      if (mid_toggle && i == 9) ext_data = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int a, p;
    bit seen;
    repeat (3) @(posedge clk);
    #2;
    // R1 power-on state
    check("R1 core_rst", int'(core_rst), 1);
    check("R1 phase", int'(phase), 0);
    check("R1 ale", int'(ale), 0);
    check("R1 psen_n", int'(psen_n), 1);
    @(negedge clk); arst_n = 1;
    repeat (5) @(posedge clk);

    run_cycle(0, 0, 0, a, p);
    check("R3 ale pulses", a, 2);
    check("R6 psen pulses no fetch", p, 0);
    run_cycle(1, 0, 0, a, p);
    check("R6 psen pulses fetch", p, 2);
    check("R3 ale pulses fetch", a, 2);
    run_cycle(1, 1, 0, a, p);
    check("R7 psen pulses data", p, 0);
    check("R4 ale pulses data", a, 1);
    run_cycle(0, 1, 0, a, p);
    check("R4 ale pulses data only", a, 1);
    run_cycle(1, 0, 1, a, p);
    check("R8 mid-cycle data ignored ale", a, 2);
    check("R8 mid-cycle data ignored psen", p, 2);

    @(negedge clk); ale_off = 1;
    run_cycle(1, 0, 0, a, p);
    check("R5 ale off pulses", a, 0);
    check("R5 psen unaffected", p, 2);
    @(negedge clk); ale_off = 0;

    // R9 short pulse: 24 clocks high must be ignored
    @(negedge clk); rst_pin = 1;
    repeat (QUAL - 1) @(negedge clk);
    rst_pin = 0;
    seen = 0;
    repeat (30) begin @(negedge clk); #3; if (core_rst) seen = 1; end
    check("R9 short pulse ignored", int'(seen), 0);

    // R9 long pulse: 26 clocks high must reset
    @(negedge clk); rst_pin = 1;
    seen = 0;
    repeat (QUAL + 1) begin @(negedge clk); #3; end
    repeat (SYNC + 1) begin @(negedge clk); #3; if (core_rst) seen = 1; end
    check("R9 long pulse accepted", int'(seen), 1);
    // R11 quiet while in reset
    check("R11 ale in reset", int'(ale), 0);
    check("R11 psen_n in reset", int'(psen_n), 1);
    check("R11 phase in reset", int'(phase), 0);
    @(negedge clk); rst_pin = 0;
    repeat (SYNC) begin @(negedge clk); #3; end
    check("R10 still held", int'(core_rst), 1);
    @(negedge clk); #3;
    check("R10 released", int'(core_rst), 0);

    run_cycle(1, 0, 0, a, p);
    check("R6 after reset psen", p, 2);
    check("R3 after reset ale", a, 2);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule